// File: doc/BRIEF.md
# Eight-Channel DAC Serial Register Controller

This block is the digital front end of an eight-channel digital-to-analog converter. A host shifts command words in over a three-wire serial port (active-low select, serial clock, serial data). When the select line returns high, the block decodes the captured word and acts on per-channel state. Each channel has an input register, a DAC register and a power-down bit. The parallel DAC codes and the power-down mask are the outputs that drive the converter cores.

Two side pins are also present. An active-low load pin transfers every input register into its DAC register at once. While that pin is held low it also keeps all channels powered. An active-low clear pin is level-sensitive and returns all state to a build-time reset code, either zero or mid-scale. All pins are asynchronous to the block clock and pass through synchronizers. The serial path is a pin-level protocol with no valid/ready handshake. It cannot apply back-pressure, so every complete frame is accepted or discarded on the spot.

Top module: `octdac_ctrl`

## Requirements
- R1: Bits are shifted in MSB first on rising edges of `sck`, only while `csn` is low. Edges on `sck` while `csn` is high have no effect.
- R2: A command takes effect only after `csn` rises. Mid-frame, the outputs do not change.
- R3: A frame of exactly 24 bits is accepted. A frame of 32 bits is also accepted, and only its last 24 bits are kept.
- R4: A frame of any other length is dropped, and no register changes.
- R5: The kept 24 bits are laid out, from first to last, as a 4-bit command, a 4-bit address and a 16-bit data field. The code is data bits [15:4]. Commands: 0 writes the input register, 1 copies input to DAC, 3 does both, and 4 powers down. Other commands do nothing. Address 0..7 picks one channel, 15 picks all channels, and 8..14 picks none.
- R6: A falling edge on `load_n` while `csn` is high copies all eight input registers into the DAC registers together.
- R7: A falling edge on `load_n` while `csn` is low waits until `csn` rises. It then copies after the command of that frame has been applied.
- R8: While `load_n` is low, `pd_mask` is all zero and command 4 is ignored.
- R9: Commands 0, 1 and 3 clear the power-down bit of each channel they address.
- R10: While `clr_n` is low, all input and DAC registers hold the reset code and `pd_mask` is zero. The reset code is 0x000, or 0x800 when `MIDSCALE` = 1. A frame open during a clear is dropped.
- R11: After `rst_n`, every DAC code equals the reset code and `pd_mask` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, sampled on its rising edge |
| csn | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load: edge copies, level keeps channels powered |
| clr_n | input | 1 | Active-low level clear of all state |
| dac_codes | output | 96 | Channel n code in bits [n*12 +: 12] |
| pd_mask | output | 8 | Bit n high: channel n powered down |

## Verification
The properties assume that every pin level lasts longer than the synchronizer depth plus one clock. They also assume that `sdi` is steady around each `sck` rise, and that `clr_n` stays low for at least one full clock. The bench drives all pins on falling clock edges and holds each serial phase for three clocks. It keeps `csn` high for several clocks between frames and holds clear low for two clocks. As a result, each edge the block detects matches one edge the bench intended.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int FRAME_W = 24;
  localparam int LONG_W  = 32;
  localparam int CNT_W   = 6;
  localparam logic [3:0] ADDR_ALL = 4'hF;

  typedef enum logic [3:0] {
    CMD_WR_IN  = 4'd0,
    CMD_UPDATE = 4'd1,
    CMD_WR_UP  = 4'd3,
    CMD_PWRDN  = 4'd4
  } cmd_e;
endpackage

// File: rtl/octdac_sync.sv
module octdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {STAGES{RST_VAL}};
    else        st <= {st[STAGES-2:0], d};
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/octdac_serial_rx.sv
module octdac_serial_rx
  import octdac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               sck_s,
  input  logic               csn_s,
  input  logic               sdi_s,
  output logic               frm_done,
  output logic               frm_vld,
  output logic [3:0]         cmd_q,
  output logic [3:0]         addr_q,
  output logic [CODE_W-1:0]  code_q,
  output logic [FRAME_W-1:0] shreg
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(LONG_W);

  logic             sck_d, csn_d, armed;
  logic [CNT_W-1:0] cnt;
  logic             sck_rise, cs_fall, cs_rise;

  assign sck_rise = sck_s && !sck_d;
  assign cs_fall  = csn_d && !csn_s;
  assign cs_rise  = !csn_d && csn_s;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sck_d    <= 1'b0;
      csn_d    <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      frm_done <= 1'b0;
      frm_vld  <= 1'b0;
      cmd_q    <= '0;
      addr_q   <= '0;
      code_q   <= '0;
    end else begin
      sck_d    <= sck_s;
      csn_d    <= csn_s;
      frm_done <= 1'b0;
      frm_vld  <= 1'b0;
      if (cs_fall) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (!csn_s && sck_rise) begin
        shreg <= {shreg[FRAME_W-2:0], sdi_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (cs_rise) begin
        frm_done <= 1'b1;
        armed    <= 1'b0;
        frm_vld  <= armed && (cnt == CNT_SHORT || cnt == CNT_LONG);
        cmd_q    <= shreg[FRAME_W-1 -: 4];
        addr_q   <= shreg[FRAME_W-5 -: 4];
        code_q   <= shreg[15 -: CODE_W];
      end
    end
  end
endmodule

// File: rtl/octdac_regfile.sv
module octdac_regfile
  import octdac_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CODE_W = 12,
  parameter bit MIDSCALE = 1'b0
) (
  input  logic                         clk,
  input  logic                         arst_n,
  input  logic                         frm_done,
  input  logic                         frm_vld,
  input  logic [3:0]                   cmd_q,
  input  logic [3:0]                   addr_q,
  input  logic [CODE_W-1:0]            code_q,
  input  logic                         csn_hi,
  input  logic                         ld_s,
  output logic [N_CH-1:0][CODE_W-1:0]  dac_q,
  output logic [N_CH-1:0]              pd_q,
  output logic                         copy_evt
);
  localparam logic [CODE_W-1:0] RST_CODE =
    MIDSCALE ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  logic [N_CH-1:0][CODE_W-1:0] in_q, in_nx, dac_nx;
  logic [N_CH-1:0]             pd_nx;
  logic                        ld_d, pend_q, pend_nx, ld_fall;
  logic                        do_wr, do_up, do_pd;

  assign ld_fall = ld_d && !ld_s;
  assign do_wr = (cmd_q == CMD_WR_IN) || (cmd_q == CMD_WR_UP);
  assign do_up = (cmd_q == CMD_UPDATE) || (cmd_q == CMD_WR_UP);
  assign do_pd = (cmd_q == CMD_PWRDN);
  assign copy_evt = (ld_fall && csn_hi) || (pend_q && frm_done);

  always_comb begin
    in_nx  = in_q;
    dac_nx = dac_q;
    pd_nx  = pd_q;
    for (int ch = 0; ch < N_CH; ch++) begin
      if (frm_vld && (addr_q == 4'(ch) || addr_q == ADDR_ALL)) begin
        if (do_wr) in_nx[ch] = code_q;
        if (do_up) dac_nx[ch] = in_nx[ch];
        if (do_wr || do_up) pd_nx[ch] = 1'b0;
        if (do_pd && ld_s) pd_nx[ch] = 1'b1;
      end
    end
    if (copy_evt) dac_nx = in_nx;
    if (!ld_s) pd_nx = '0;
    if (frm_done) pend_nx = 1'b0;
    else if (ld_fall && !csn_hi) pend_nx = 1'b1;
    else pend_nx = pend_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      in_q   <= {N_CH{RST_CODE}};
      dac_q  <= {N_CH{RST_CODE}};
      pd_q   <= '0;
      ld_d   <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      in_q   <= in_nx;
      dac_q  <= dac_nx;
      pd_q   <= pd_nx;
      ld_d   <= ld_s;
      pend_q <= pend_nx;
    end
  end
endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
  import octdac_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CODE_W = 12,
  parameter bit MIDSCALE = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck,
  input  logic                     csn,
  input  logic                     sdi,
  input  logic                     load_n,
  input  logic                     clr_n,
  output logic [N_CH*CODE_W-1:0]   dac_codes,
  output logic [N_CH-1:0]          pd_mask
);
  logic                        arst_n;
  logic [3:0]                  pins_s;
  logic                        sck_s, csn_s, sdi_s, ld_s;
  logic                        frm_done, frm_vld, copy_evt;
  logic [3:0]                  cmd_q, addr_q;
  logic [CODE_W-1:0]           code_q;
  logic [FRAME_W-1:0]          shreg;
  logic [N_CH-1:0][CODE_W-1:0] dac_q;

  assign arst_n = rst_n & clr_n;

  octdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({csn, sck, sdi, load_n}), .q(pins_s)
  );
  assign {csn_s, sck_s, sdi_s, ld_s} = pins_s;

  octdac_serial_rx #(.CODE_W(CODE_W)) u_rx (
    .clk(clk), .arst_n(arst_n),
    .sck_s(sck_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .frm_done(frm_done), .frm_vld(frm_vld),
    .cmd_q(cmd_q), .addr_q(addr_q), .code_q(code_q), .shreg(shreg)
  );

  octdac_regfile #(.N_CH(N_CH), .CODE_W(CODE_W), .MIDSCALE(MIDSCALE)) u_regs (
    .clk(clk), .arst_n(arst_n),
    .frm_done(frm_done), .frm_vld(frm_vld),
    .cmd_q(cmd_q), .addr_q(addr_q), .code_q(code_q),
    .csn_hi(csn_s), .ld_s(ld_s),
    .dac_q(dac_q), .pd_q(pd_mask), .copy_evt(copy_evt)
  );

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_out
      assign dac_codes[ch*CODE_W +: CODE_W] = dac_q[ch];
    end
  endgenerate
endmodule

// File: rtl/octdac_ctrl_chk.sv
module octdac_ctrl_chk
  import octdac_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CODE_W = 12,
  parameter bit MIDSCALE = 1'b0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clr_n,
  input logic [N_CH*CODE_W-1:0] dac_codes,
  input logic [N_CH-1:0]        pd_mask,
  input logic                   ld_lvl,
  input logic                   csn_lvl,
  input logic                   frm_done,
  input logic                   frm_vld,
  input logic                   copy_evt,
  input logic [FRAME_W-1:0]     shreg
);
  localparam logic [CODE_W-1:0] RST_CODE =
    MIDSCALE ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  p_shift_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    csn_lvl |=> ($stable(shreg) || !clr_n));

  p_frame_after_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> csn_lvl);

  p_dac_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_vld && !copy_evt) |=> ($stable(dac_codes) || !clr_n));

  p_load_powers_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_lvl |=> (pd_mask == '0));

  p_clear_codes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_codes == {N_CH{RST_CODE}} && pd_mask == '0));
endmodule

bind octdac_ctrl octdac_ctrl_chk #(.N_CH(N_CH), .CODE_W(CODE_W), .MIDSCALE(MIDSCALE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
  .dac_codes(dac_codes), .pd_mask(pd_mask),
  .ld_lvl(ld_s), .csn_lvl(csn_s),
  .frm_done(frm_done), .frm_vld(frm_vld), .copy_evt(copy_evt),
  .shreg(shreg)
);

// File: tb/octdac_ctrl_test.sv
`timescale 1ns/1ps
module octdac_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, sck = 1'b0, csn = 1'b1, sdi = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic [95:0] codes, codes_mid;
  logic [7:0]  pd, pd_mid;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  octdac_ctrl uut (.clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .sdi(sdi),
    .load_n(load_n), .clr_n(clr_n), .dac_codes(codes), .pd_mask(pd));
  octdac_ctrl #(.MIDSCALE(1'b1)) uut_mid (.clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn),
    .sdi(sdi), .load_n(load_n), .clr_n(clr_n), .dac_codes(codes_mid), .pd_mask(pd_mid));

  // {length, frame bits, channel to check, expected code, expected pd mask}
  localparam logic [60:0] VEC [12] = '{
    {6'd24, 32'h0032ABC0, 3'd2, 12'hABC, 8'h00},  // R5 write+update
    {6'd24, 32'h00051230, 3'd5, 12'h000, 8'h00},  // R5 input write only
    {6'd24, 32'h00150000, 3'd5, 12'h123, 8'h00},  // R5 update
    {6'd24, 32'h00420000, 3'd2, 12'hABC, 8'h04},  // R5 power down
    {6'd32, 32'hFF327770, 3'd2, 12'h777, 8'h00},  // R3 long frame, R9 power up
    {6'd24, 32'h003F4560, 3'd7, 12'h456, 8'h00},  // R5 broadcast
    {6'd23, 32'h0030FFF0, 3'd0, 12'h456, 8'h00},  // R4 short frame
    {6'd25, 32'h0030FFF0, 3'd0, 12'h456, 8'h00},  // R4 odd length
    {6'd24, 32'h00201110, 3'd0, 12'h456, 8'h00},  // R5 unused command
    {6'd24, 32'h00399990, 3'd1, 12'h456, 8'h00},  // R5 unused address
    {6'd24, 32'h004F0000, 3'd3, 12'h456, 8'hFF},  // R5 broadcast power down
    {6'd24, 32'h000F0F00, 3'd6, 12'h456, 8'h00}   // R9 write powers up all
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(3);
      sck = 1'b1;
      wait_clk(3);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] w, input int n);
    csn = 1'b0;
    wait_clk(4);
    shift(w, n);
    wait_clk(3);
    csn = 1'b1;
    wait_clk(10);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    wait_clk(6);
    load_n = 1'b1;
    wait_clk(8);
  endtask

  function automatic logic [11:0] ch_code(input logic [95:0] c, input int ch);
    return c[ch*12 +: 12];
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R11 reset state
    chk("R11 codes", codes[31:0], 32'h0);
    chk("R11 codes hi", codes[95:64], 32'h0);
    chk("R11 pd", pd, 0);
    chk("R11 midscale ch0", ch_code(codes_mid, 0), 12'h800);
    chk("R11 midscale ch7", ch_code(codes_mid, 7), 12'h800);

    for (int v = 0; v < 12; v++) begin
      send(VEC[v][54:23], int'(VEC[v][60:55]));
      chk($sformatf("R5/R3/R4/R9 vec%0d code", v),
          ch_code(codes, int'(VEC[v][22:20])), VEC[v][19:8]);
      chk($sformatf("R5/R9 vec%0d pd", v), pd, VEC[v][7:0]);
    end

    // R6: all input registers hold 0x0F0 now, copy with select high
    pulse_load();
    chk("R6 ch0", ch_code(codes, 0), 12'h0F0);
    chk("R6 ch7", ch_code(codes, 7), 12'h0F0);

    // R7: load during an open frame waits for its end
    send(32'h013210, 24);
    csn = 1'b0;
    wait_clk(4);
    shift(32'h036, 12);
    pulse_load();
    chk("R7 R2 ch1 mid-frame", ch_code(codes, 1), 12'h0F0);
    shift(32'h540, 12);
    wait_clk(3);
    csn = 1'b1;
    wait_clk(10);
    chk("R7 ch1 after frame", ch_code(codes, 1), 12'h321);
    chk("R7 ch3 same-frame write copied", ch_code(codes, 3), 12'h654);

    // R1: clock edges while not selected do nothing
    sdi = 1'b1;
    for (int k = 0; k < 30; k++) begin
      sck = 1'b1; wait_clk(3); sck = 1'b0; wait_clk(3);
    end
    csn = 1'b0; wait_clk(4); wait_clk(3); csn = 1'b1; wait_clk(10);
    chk("R1 ch3 unchanged", ch_code(codes, 3), 12'h654);
    send(32'h000ABC0, 24); // cmd0 addr0: input only, MSB first
    send(32'h0100000, 24); // update ch0
    chk("R1 MSB-first ch0", ch_code(codes, 0), 12'hABC);

    // R8: load level low blocks power down and forces power up
    load_n = 1'b0;
    wait_clk(6);
    send(32'h400000, 24);
    chk("R8 pd ignored", pd, 0);
    load_n = 1'b1;
    wait_clk(6);
    send(32'h400000, 24);
    chk("R5 pd ch0", pd, 8'h01);
    load_n = 1'b0;
    wait_clk(6);
    chk("R8 level powers up", pd, 0);
    load_n = 1'b1;
    wait_clk(6);

    // R10: clear
    send(32'h34EEE0, 24);
    send(32'h420000, 24);
    chk("R10 pre ch4", ch_code(codes, 4), 12'hEEE);
    @(negedge clk);
    clr_n = 1'b0;
    #2;
    chk("R10 codes zero", codes[63:32], 32'h0);
    chk("R10 ch4 zero", ch_code(codes, 4), 12'h0);
    chk("R10 pd zero", pd, 0);
    chk("R10 midscale ch4", ch_code(codes_mid, 4), 12'h800);
    wait_clk(2);
    clr_n = 1'b1;
    wait_clk(4);
    send(32'h100000, 24); // update ch0 from cleared input
    chk("R10 input cleared", ch_code(codes, 0), 12'h000);
    // frame open across a clear is dropped
    csn = 1'b0;
    wait_clk(4);
    shift(32'h30A, 12);
    clr_n = 1'b0;
    wait_clk(2);
    clr_n = 1'b1;
    shift(32'hAA0, 12);
    wait_clk(3);
    csn = 1'b1;
    wait_clk(10);
    chk("R10 partial frame dropped", ch_code(codes, 0), 12'h000);

    done = 1'b1;
    finish_run();
  end
endmodule